// File: doc/BRIEF.md
# Address Acknowledge Generator

This block sits on the slave side of a split-transaction processor bus and produces the strobe that ends the address phase of a transfer. It samples the transfer-start strobe. It then counts a programmed number of clocks and issues a single-cycle acknowledge. If a retry condition is still pending when the count completes, it holds the acknowledge back until that condition clears.

The programmed delay is clamped so that the acknowledge never comes sooner than two clocks after the start strobe. While the block is counting, further start strobes are not taken. The count is abandoned without an acknowledge in two cases: the address bus stops being busy, or the internal-only mode bit is set. In internal-only mode the address phase needs no termination, so the block stays silent.

Top module: `aack_gen`

## Requirements
- R1: After synchronous reset `ack_o` is low, and it stays low until a transfer start is accepted.
- R2: A start strobe sampled high at clock edge S, while the block is idle and `int_only_i` is low, is accepted. Without a pending retry, `ack_o` is then high in the cycle after edge S+D, where D is the delay word sampled at edge S.
- R3: Delay words below 2 behave as 2: the acknowledge follows edge S+2.
- R4: `ack_o` is high for exactly one cycle for each accepted start.
- R5: If `retry_pend_i` is sampled high at the edge where the count completes, the acknowledge is issued at the first later edge where `retry_pend_i` is sampled low. No acknowledge is issued at an edge where `retry_pend_i` is high.
- R6: A start strobe that arrives while a count or a retry wait is in progress is ignored. It neither restarts nor shortens the current count.
- R7: While `int_only_i` is high, no start is accepted. If it rises during a count, that count ends with no acknowledge.
- R8: If `bus_busy_i` is sampled low at any edge after acceptance and before the acknowledge, the transfer ends with no acknowledge.
- R9: Each accepted start restarts the delay count from zero. A second transfer accepted right after an acknowledge gets its full programmed delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ts_i | input | 1 | Transfer-start strobe, active high |
| bus_busy_i | input | 1 | Address bus busy indication, active high |
| dly_cfg_i | input | DLY_W | Programmed acknowledge delay in clocks |
| retry_pend_i | input | 1 | Retry condition still unresolved |
| int_only_i | input | 1 | Internal-only mode; suppresses all acknowledges |
| ack_o | output | 1 | Registered address acknowledge pulse |

## Verification
The hardest case to reach is a retry that stays pending past the end of the count. The stimulus raises `retry_pend_i` together with the start strobe and keeps it high for longer than the programmed delay, so the block must wait in its hold state. A second case places a stray start strobe in the middle of a count. A third drops bus-busy or raises internal-only mode during a count. For these the scoreboard expects no acknowledge, and any pulse on `ack_o` is reported as unexpected.

// File: rtl/aack_pkg.sv
package aack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } aack_state_e;

  localparam int unsigned MIN_LAT = 2;
endpackage

// File: rtl/aack_clamp.sv
module aack_clamp #(
  parameter int unsigned DLY_W   = 4,
  parameter int unsigned MIN_LAT = 2
) (
  input  logic [DLY_W-1:0] cfg_i,
  output logic [DLY_W-1:0] eff_o
);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(MIN_LAT);

  always_comb begin
    eff_o = (cfg_i < FLOOR) ? FLOOR : cfg_i;
  end
endmodule

// File: rtl/aack_timer.sv
module aack_timer #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic [DLY_W-1:0] cnt_o,
  output logic             reached_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= DLY_W'(1);
    end else if (run_i && (cnt_q < limit_i)) begin
      cnt_q <= cnt_q + DLY_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign reached_o = (cnt_q >= limit_i);
endmodule

// File: rtl/aack_gen.sv
module aack_gen
  import aack_pkg::*;
#(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts_i,
  input  logic             bus_busy_i,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic             retry_pend_i,
  input  logic             int_only_i,
  output logic             ack_o
);
  aack_state_e      st_q;
  logic [DLY_W-1:0] eff_dly;
  logic [DLY_W-1:0] lim_q;
  logic [DLY_W-1:0] cnt;
  logic             reached;
  logic             accept;
  logic             abort;
  logic             ack_q;

  aack_clamp #(.DLY_W(DLY_W), .MIN_LAT(MIN_LAT)) u_clamp (
    .cfg_i (dly_cfg_i),
    .eff_o (eff_dly)
  );

  assign accept = (st_q == ST_IDLE) && ts_i && !int_only_i;
  assign abort  = int_only_i || !bus_busy_i;

  aack_timer #(.DLY_W(DLY_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (accept),
    .run_i     (st_q == ST_COUNT),
    .limit_i   (lim_q),
    .cnt_o     (cnt),
    .reached_o (reached)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
      lim_q <= DLY_W'(MIN_LAT);
    end else begin
      ack_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q  <= ST_COUNT;
            lim_q <= eff_dly;
          end
        end
        ST_COUNT: begin
          if (abort) begin
            st_q <= ST_IDLE;
          end else if (reached) begin
            if (retry_pend_i) begin
              st_q <= ST_HOLD;
            end else begin
              ack_q <= 1'b1;
              st_q  <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (abort) begin
            st_q <= ST_IDLE;
          end else if (!retry_pend_i) begin
            ack_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/aack_gen_chk.sv
module aack_gen_chk #(
  parameter int unsigned DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_busy_i,
  input logic             retry_pend_i,
  input logic             int_only_i,
  input logic [DLY_W-1:0] cnt,
  input logic             ack_o
);
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !ack_o);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  a_r3_min_latency: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (cnt >= DLY_W'(2)));

  a_r5_no_ack_during_retry: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(retry_pend_i));

  a_r7_internal_silent: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(int_only_i));

  a_r8_busy_needed: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(bus_busy_i));
endmodule

bind aack_gen aack_gen_chk #(.DLY_W(DLY_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_busy_i   (bus_busy_i),
  .retry_pend_i (retry_pend_i),
  .int_only_i   (int_only_i),
  .cnt          (cnt),
  .ack_o        (ack_o)
);

// File: tb/sim_aack_gen.sv
module sim_aack_gen;
  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ts_i = 1'b0;
  logic             bus_busy_i = 1'b0;
  logic [DLY_W-1:0] dly_cfg_i = '0;
  logic             retry_pend_i = 1'b0;
  logic             int_only_i = 1'b0;
  logic             ack_o;

  int     n_checks = 0;
  int     n_fails  = 0;
  int     cyc      = 0;
  int     exp_q[$];
  string  tag      = "R1";
  bit     done     = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  aack_gen #(.DLY_W(DLY_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .ts_i         (ts_i),
    .bus_busy_i   (bus_busy_i),
    .dly_cfg_i    (dly_cfg_i),
    .retry_pend_i (retry_pend_i),
    .int_only_i   (int_only_i),
    .ack_o        (ack_o)
  );

  // Monitor: each ack pulse is compared with the head of the expectation queue.
  always @(negedge clk) begin
    if (!rst && ack_o) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL %s: unexpected ack at edge %0d (actual 1, expected 0)", tag, cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          n_fails++;
          $display("FAIL %s: ack at edge %0d, expected edge %0d", tag, cyc, e);
        end
      end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic int clampd(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  // Driver: one transfer. r = number of edges (from S) with retry high.
  // stray = offset of an extra start strobe during the count (0 = none).
  // kill  = 0 none, 1 drop busy, 2 raise internal-only, at edge S+kill_at.
  task automatic xfer(input string t, input int d, input int r,
                      input int stray, input int kill, input int kill_at);
    int s, e, last;
    tag = t;
    dly_cfg_i    = DLY_W'(d);
    ts_i         = 1'b1;
    bus_busy_i   = 1'b1;
    retry_pend_i = (r > 0);
    s = cyc + 1;
    e = s + clampd(d);
    if (r > 0 && s + r > e) e = s + r;
    if (kill == 0) exp_q.push_back(e);
    last = e + 2;
    while (cyc < last) begin
      @(negedge clk);
      ts_i = (stray > 0 && cyc == s + stray - 1);
      if (r > 0 && cyc == s + r - 1) retry_pend_i = 1'b0;
      if (kill == 1 && cyc == s + kill_at - 1) bus_busy_i = 1'b0;
      if (kill == 2 && cyc == s + kill_at - 1) int_only_i = 1'b1;
    end
    ts_i = 1'b0;
    retry_pend_i = 1'b0;
    bus_busy_i = 1'b0;
    int_only_i = 1'b0;
    @(negedge clk);
    check({t, " pending expectations"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack low in reset", int'(ack_o), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 ack low after reset", int'(ack_o), 0);

    xfer("R2 delay 5",   5, 0, 0, 0, 0);
    xfer("R2 delay 15", 15, 0, 0, 0, 0);
    xfer("R3 delay 0",   0, 0, 0, 0, 0);
    xfer("R3 delay 1",   1, 0, 0, 0, 0);
    xfer("R4 delay 2",   2, 0, 0, 0, 0);
    xfer("R5 retry long", 3, 8, 0, 0, 0);
    xfer("R5 retry short", 4, 1, 0, 0, 0);
    xfer("R5 retry equal", 6, 6, 0, 0, 0);
    xfer("R6 stray start", 9, 0, 3, 0, 0);
    xfer("R6 stray during retry", 2, 5, 4, 0, 0);
    xfer("R7 internal mid count", 8, 0, 0, 2, 3);
    xfer("R8 busy drop", 8, 0, 0, 1, 4);
    xfer("R8 busy drop in retry wait", 2, 9, 0, 1, 5);

    // R7: start strobe with internal-only mode already set is never taken.
    tag = "R7 start while internal";
    int_only_i = 1'b1;
    bus_busy_i = 1'b1;
    dly_cfg_i  = DLY_W'(2);
    ts_i = 1'b1;
    @(negedge clk);
    ts_i = 1'b0;
    repeat (6) @(negedge clk);
    int_only_i = 1'b0;
    bus_busy_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 no ack while internal", exp_q.size(), 0);

    // R9: back-to-back transfers each get their full delay.
    begin
      int s1, s2;
      tag = "R9 back to back";
      bus_busy_i = 1'b1;
      dly_cfg_i = DLY_W'(4);
      ts_i = 1'b1;
      s1 = cyc + 1;
      exp_q.push_back(s1 + 4);
      @(negedge clk);
      ts_i = 1'b0;
      while (cyc < s1 + 4) @(negedge clk);
      dly_cfg_i = DLY_W'(7);
      ts_i = 1'b1;
      s2 = cyc + 1;
      exp_q.push_back(s2 + 7);
      @(negedge clk);
      ts_i = 1'b0;
      while (cyc < s2 + 9) @(negedge clk);
      bus_busy_i = 1'b0;
      @(negedge clk);
      check("R9 both acks seen", exp_q.size(), 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule